// File: doc/BRIEF.md
# Registered I/O Cell with Scan Chain

This block is a one-bit I/O cell for the boundary of a programmable logic fabric. It carries data in two directions. The outbound path takes a bit from the fabric and drives it to the pad. The inbound path takes the pad's input bit and presents it to the fabric. A static configuration bit for each path chooses between a combinational bypass and a registered version that adds one clock of latency.

The cell holds exactly two flip-flops, both clocked by one dedicated I/O clock. When scan is enabled, the same two flip-flops form a two-stage shift chain. Scan data enters the outbound register, moves on to the inbound register, and leaves on the scan output.

The data and control pins are plain single-bit signals with no handshake. The pad path has no back-pressure. The clock, reset and scan pins are dedicated signals that are not reached from general routing. Tristate control and the loading of the configuration bits are handled outside this block.

Top module: `io_scan_cell`

## Requirements
- R1: Reset (`rst`, active-high, synchronous) clears both flip-flops to 0 at the clock edge where it is sampled high. After that edge, `scan_out` reads 0 and any registered path reads 0.
- R2: With `cfg_sel[0]` = 0 (outbound bypass), `pad_o` equals `core_dout` in the same cycle, with no clock between them.
- R3: With `cfg_sel[0]` = 1 (outbound registered), `pad_o` equals the value of `core_dout` sampled at the previous rising edge, when scan is off and reset is low.
- R4: With `cfg_sel[1]` = 0 (inbound bypass), `core_din` equals `pad_i` in the same cycle.
- R5: With `cfg_sel[1]` = 1 (inbound registered), `core_din` equals the value of `pad_i` sampled at the previous rising edge, when scan is off and reset is low.
- R6: With `scan_en` = 1, the outbound register loads `scan_in` and the inbound register loads the outbound register's old value. A bit applied at `scan_in` therefore appears at `scan_out` after two rising edges.
- R7: `scan_out` always shows the inbound register. In normal mode this means `scan_out` equals `pad_i` from the previous edge, whatever the value of `cfg_sel`.
- R8: While `scan_en` = 1, `core_dout` and `pad_i` have no effect on either register. The contents of both registers stay a pure function of `scan_in`, which can be seen at `scan_out` and at `pad_o`/`core_din` in registered mode.
- R9: Reset takes priority over scan. With `rst` = 1 and `scan_en` = 1, both registers still clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated I/O clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of both flip-flops |
| scan_en | input | 1 | 1 selects the scan shift, 0 selects normal capture |
| scan_in | input | 1 | Serial scan data into the outbound register |
| scan_out | output | 1 | Serial scan data from the inbound register |
| cfg_sel | input | 2 | Bit 0: outbound registered (1) or bypass (0); bit 1: inbound registered (1) or bypass (0) |
| core_dout | input | 1 | Data from the fabric towards the pad |
| pad_o | output | 1 | Data driven to the pad |
| pad_i | input | 1 | Data received from the pad |
| core_din | output | 1 | Data delivered to the fabric |

## Verification
Bypassed paths are due in the same cycle as their input. The bench checks them a short delay after driving the inputs on the falling edge. Registered paths and `scan_out` change one rising edge after capture, and a scan bit reaches `scan_out` two edges after it is applied. The bench therefore advances a small arithmetic model of the two registers only at each rising edge, and compares all three outputs at the following falling edge. Under every configuration and scan setting, the bench sweeps every combination of `core_dout`, `pad_i` and `scan_in` over a fixed 64-step pattern, with a reset pulse placed inside each sweep.

// File: rtl/io_cell_pkg.sv
package io_cell_pkg;
  localparam int CFG_W       = 2;
  localparam int OUT_REG_BIT = 0;
  localparam int IN_REG_BIT  = 1;

  typedef enum logic {
    PATH_BYPASS     = 1'b0,
    PATH_REGISTERED = 1'b1
  } path_mode_e;
endpackage

// File: rtl/io_scan_ff.sv
module io_scan_ff #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic scan_en,
  input  logic func_d,
  input  logic scan_d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= RST_VAL;
    else if (scan_en) q <= scan_d;
    else              q <= func_d;
  end

  // R1 / R9: reset clears the flop even while scan is on
  assert_rst_clear_R1: assert property (@(posedge clk) rst |=> (q == RST_VAL));
  // R9: reset wins over scan_en
  assert_rst_over_scan_R9: assert property (@(posedge clk) (rst && scan_en) |=> (q == RST_VAL));
  // R6: scan capture
  assert_scan_load_R6: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (q == $past(scan_d)));
endmodule

// File: rtl/io_path_mux.sv
module io_path_mux
  import io_cell_pkg::*;
(
  input  path_mode_e mode,
  input  logic       direct_i,
  input  logic       reg_i,
  output logic       y
);
  always_comb begin
    unique case (mode)
      PATH_REGISTERED: y = reg_i;
      default:         y = direct_i;
    endcase
  end
endmodule

// File: rtl/io_scan_cell.sv
module io_scan_cell
  import io_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [CFG_W-1:0] cfg_sel,
  input  logic             core_dout,
  output logic             pad_o,
  input  logic             pad_i,
  output logic             core_din
);
  logic out_q;
  logic in_q;
  path_mode_e out_mode;
  path_mode_e in_mode;

  assign out_mode = path_mode_e'(cfg_sel[OUT_REG_BIT]);
  assign in_mode  = path_mode_e'(cfg_sel[IN_REG_BIT]);

  // Stage 0: outbound register, head of the scan chain
  io_scan_ff #(.RST_VAL(1'b0)) u_out_ff (
    .clk(clk), .rst(rst), .scan_en(scan_en),
    .func_d(core_dout), .scan_d(scan_in), .q(out_q)
  );

  // Stage 1: inbound register, tail of the scan chain
  io_scan_ff #(.RST_VAL(1'b0)) u_in_ff (
    .clk(clk), .rst(rst), .scan_en(scan_en),
    .func_d(pad_i), .scan_d(out_q), .q(in_q)
  );

  io_path_mux u_out_mux (
    .mode(out_mode), .direct_i(core_dout), .reg_i(out_q), .y(pad_o)
  );

  io_path_mux u_in_mux (
    .mode(in_mode), .direct_i(pad_i), .reg_i(in_q), .y(core_din)
  );

  assign scan_out = in_q;

  // R2 / R4: bypass paths are combinational
  always_comb begin
    if (cfg_sel[OUT_REG_BIT] == 1'b0) assert_out_bypass_R2: assert (pad_o == core_dout);
    if (cfg_sel[IN_REG_BIT] == 1'b0)  assert_in_bypass_R4: assert (core_din == pad_i);
  end

  // R3: registered outbound path, one cycle
  assert_out_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && cfg_sel[OUT_REG_BIT]) ##1 cfg_sel[OUT_REG_BIT] |-> (pad_o == $past(core_dout)));
  // R5: registered inbound path, one cycle
  assert_in_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && cfg_sel[IN_REG_BIT]) ##1 cfg_sel[IN_REG_BIT] |-> (core_din == $past(pad_i)));
  // R7: scan_out follows pad_i in normal mode
  assert_scan_out_normal_R7: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> (scan_out == $past(pad_i)));
  // R6 / R8: two-edge scan transit independent of functional inputs
  assert_scan_two_edge_R6: assert property (@(posedge clk) disable iff (rst)
    scan_en ##1 scan_en |=> (scan_out == $past(scan_in, 2)));
endmodule

// File: tb/sim_io_scan_cell.sv
`timescale 1ns/1ps
module sim_io_scan_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scan_en = 1'b0;
  logic       scan_in = 1'b0;
  logic [1:0] cfg_sel = 2'b11;
  logic       core_dout = 1'b0;
  logic       pad_i = 1'b0;
  logic       scan_out, pad_o, core_din;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic ea = 1'b0;
  logic eb = 1'b0;

  always #2 clk = ~clk;

  io_scan_cell u0 (
    .clk(clk), .rst(rst), .scan_en(scan_en), .scan_in(scan_in),
    .scan_out(scan_out), .cfg_sel(cfg_sel), .core_dout(core_dout),
    .pad_o(pad_o), .pad_i(pad_i), .core_din(core_din)
  );

  task automatic check(input logic got, input logic exp, input string tag);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  task automatic check_all();
    check(pad_o,    cfg_sel[0] ? ea : core_dout, cfg_sel[0] ? "R3 pad_o" : "R2 pad_o");
    check(core_din, cfg_sel[1] ? eb : pad_i,     cfg_sel[1] ? "R5 core_din" : "R4 core_din");
    check(scan_out, eb, "R7 scan_out");
  endtask

  task automatic edge_update();
    @(posedge clk);
    if (rst) begin ea = 1'b0; eb = 1'b0; end
    else if (scan_en) begin eb = ea; ea = scan_in; end
    else begin ea = core_dout; eb = pad_i; end
  endtask

  initial begin
    // reset state
    repeat (2) edge_update();
    @(negedge clk); #1;
    check(scan_out, 1'b0, "R1 scan_out after reset");
    check(pad_o,    1'b0, "R1 pad_o after reset");
    check(core_din, 1'b0, "R1 core_din after reset");
    rst = 1'b0;

    // sweep: every config x scan mode x 64 input steps
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        for (int i = 0; i < 64; i++) begin
          @(negedge clk);
          cfg_sel   = c[1:0];
          scan_en   = s[0];
          core_dout = i[0];
          pad_i     = i[1] ^ i[3];
          scan_in   = i[2] ^ i[4] ^ i[5];
          rst       = (i == 40);
          #1;
          if (!rst) check_all();
          if (s == 1) check(scan_out, eb, "R6 R8 scan path");
          edge_update();
        end
      end
    end

    // R9: reset while scanning ones
    @(negedge clk); rst = 1'b0; scan_en = 1'b1; scan_in = 1'b1; cfg_sel = 2'b11;
    edge_update();
    edge_update();
    @(negedge clk); #1;
    check(scan_out, 1'b1, "R6 two-edge scan transit");
    rst = 1'b1;
    edge_update();
    @(negedge clk); #1;
    check(scan_out, 1'b0, "R9 scan_out reset over scan");
    check(pad_o,    1'b0, "R9 pad_o reset over scan");
    check(core_din, 1'b0, "R1 core_din cleared");

    // R8: functional inputs toggle during scan, registers follow scan_in only
    rst = 1'b0; scan_in = 1'b0; core_dout = 1'b1; pad_i = 1'b1;
    edge_update();
    @(negedge clk); #1;
    check(pad_o,    1'b0, "R8 pad_o ignores core_dout in scan");
    check(core_din, 1'b0, "R8 core_din ignores pad_i in scan");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired t=%0t got=hung exp=done", $time);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule